// File: doc/BRIEF.md
# Latency-Hiding Prefetching Texture Cache

This block is a direct-mapped texture cache built to keep a texel request stream moving while line fills are still on their way from memory. Each request has its tag looked up the moment it is accepted. A miss allocates one of a small set of miss slots and sends a line read to memory. The request itself then enters a delay queue whose minimum residency is chosen to be longer than the usual memory round trip. By the time the request reaches the end of the queue its line has normally arrived, so the readout at the tail is almost always a hit.

Memory responses are tagged with the miss slot that asked for them and may come back in any order and after any delay. Each returned line is written into the data store and clears the waiting flag of every queued entry that refers to that line index. The entry at the head of the queue leaves only when its minimum delay has passed and its line is present. Until then the output simply holds. Lines that have a fill outstanding, or that queued entries still refer to, are protected from replacement. A request that would evict such a line is held off with ready low, as is a new miss when all miss slots are busy.

A texel address is split from the low end into a 2-bit texel offset within a 4-texel line, an index into the line store, and a tag. The line address sent to memory is the texel address without its offset bits. Texel k of a returned line sits in bits [k*TEXEL_W +: TEXEL_W] of the response data.

Top module: `tex_prefetch_cache`

## Requirements
- R1: While reset is asserted and on the first cycle after it, outValid and memReqValid are low, all tags are invalid and every miss slot is free, so reqReady is high.
- R2: Every accepted request produces exactly one output whose outData is texel (address bits [1:0]) of the line that holds its address, and whose outId equals the request's reqId.
- R3: A request leaves the output no sooner than MIN_DELAY cycles after the edge at which it was accepted. A hit into an empty queue with outReady high leaves exactly MIN_DELAY cycles after it was accepted.
- R4: A miss issues one memory request carrying the line address (texel address bits above the offset) and a slot number. It does not lower reqReady for a following request to another free line.
- R5: A request whose line already has a fill outstanding is accepted without issuing another memory request.
- R6: At most NUM_MSHR line fills are outstanding. A further miss is held off with reqReady low until a response frees a slot.
- R7: While the head entry's line is still pending, outValid stays low, even after the minimum delay has passed. No entry is lost.
- R8: A request that maps to a line index holding a different tag is held off with reqReady low while that line is pending or any queued entry refers to it.
- R9: While outValid is high and outReady is low, outValid stays high and outData and outId do not change.
- R10: Responses may return in any order. Each response completes the fill for the slot named by memRspSlot.
- R11: Outputs appear in the order in which the requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Texel request present |
| reqReady | output | 1 | Request accepted this cycle when reqValid is high |
| reqAddr | input | ADDR_W | Texel address |
| reqId | input | ID_W | Caller tag returned with the texel |
| outValid | output | 1 | Texel result present |
| outReady | input | 1 | Consumer takes the result |
| outData | output | TEXEL_W | Texel value |
| outId | output | ID_W | Tag of the request this texel answers |
| memReqValid | output | 1 | Line read request present |
| memReqReady | input | 1 | Memory takes the read request |
| memReqLine | output | ADDR_W-2 | Line address to read |
| memReqSlot | output | log2(NUM_MSHR) | Miss slot to echo in the response |
| memRspValid | input | 1 | Line data returned (always taken) |
| memRspSlot | input | log2(NUM_MSHR) | Miss slot this line answers |
| memRspData | input | 4*TEXEL_W | Line of four texels, texel 0 in the low bits |

## Verification
The bench uses the defaults: 12-bit addresses, eight lines, four miss slots, a sixteen-entry queue and a minimum delay of twelve cycles. Its memory stub answers in three to eight cycles, out of order. With only eight indices, collisions that exercise the replacement lock are easy to provoke, and four slots are used up by a short burst of misses. The stub can also hold every response back for far longer than the minimum delay. This lets the bench show that a pending head stalls the output and that a fifth miss is refused, and a mixed phase then layers output and memory backpressure on top.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int TEXELS_PER_LINE = 4;
  localparam int OFF_W = 2;

  // Per-cycle strobes from the control to the datapath.
  typedef struct packed {
    logic push;      // enqueue the accepted request
    logic pushPend;  // its line is not yet present
    logic fill;      // a returned line is written this cycle
  } tcStrobe_t;

endpackage

// File: rtl/tc_ctrl.sv
module tc_ctrl
  import tc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_LINES = 8,
  parameter int NUM_MSHR  = 4,
  parameter int DEPTH     = 16,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int SLOT_W = $clog2(NUM_MSHR),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  input  logic              fifoFull,
  input  logic              popFire,
  input  logic [IDX_W-1:0]  popIdx,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [LINE_W-1:0] memReqLine,
  output logic [SLOT_W-1:0] memReqSlot,
  input  logic              memRspValid,
  input  logic [SLOT_W-1:0] memRspSlot,
  output tcStrobe_t         strobe,
  output logic [IDX_W-1:0]  fillIdx
);

  logic [TAG_W-1:0]     tagArr   [NUM_LINES];
  logic [NUM_LINES-1:0] tagValid;
  logic [NUM_LINES-1:0] pending;
  logic [CNT_W-1:0]     refCnt   [NUM_LINES];

  logic [NUM_MSHR-1:0]  mshrBusy;
  logic [NUM_MSHR-1:0]  mshrIssued;
  logic [IDX_W-1:0]     mshrIdx  [NUM_MSHR];
  logic [LINE_W-1:0]    mshrLine [NUM_MSHR];

  logic              issueHeld;
  logic [SLOT_W-1:0] heldSlot;

  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [LINE_W-1:0] reqLine;
  logic              tagHit, locked, accept, isMiss;
  logic              freeFound, issueFound;
  logic [SLOT_W-1:0] freeSlot, pickSlot, issueSlot;

  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqLine = reqAddr[ADDR_W-1:OFF_W];

  assign tagHit = tagValid[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign locked = pending[reqIdx] || (refCnt[reqIdx] != '0);

  // Lowest free miss slot, and lowest slot still waiting to be issued.
  always_comb begin
    freeFound  = 1'b0;
    freeSlot   = '0;
    issueFound = 1'b0;
    pickSlot   = '0;
    for (int s = NUM_MSHR - 1; s >= 0; s--) begin
      if (!mshrBusy[s]) begin
        freeFound = 1'b1;
        freeSlot  = SLOT_W'(s);
      end
      if (mshrBusy[s] && !mshrIssued[s]) begin
        issueFound = 1'b1;
        pickSlot   = SLOT_W'(s);
      end
    end
  end

  // A stalled memory request keeps its slot until memory takes it.
  assign issueSlot   = issueHeld ? heldSlot : pickSlot;
  assign memReqValid = issueHeld || issueFound;
  assign memReqLine  = mshrLine[issueSlot];
  assign memReqSlot  = issueSlot;

  assign reqReady = !fifoFull && (tagHit || (!locked && freeFound));
  assign accept   = reqValid && reqReady;
  assign isMiss   = accept && !tagHit;

  assign fillIdx = mshrIdx[memRspSlot];

  always_comb begin
    strobe.push     = accept;
    strobe.fill     = memRspValid;
    strobe.pushPend = isMiss ||
                      (pending[reqIdx] && !(memRspValid && (fillIdx == reqIdx)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tagValid   <= '0;
      pending    <= '0;
      mshrBusy   <= '0;
      mshrIssued <= '0;
      issueHeld  <= 1'b0;
      heldSlot   <= '0;
    end else begin
      issueHeld <= memReqValid && !memReqReady;
      heldSlot  <= issueSlot;
      if (memReqValid && memReqReady) mshrIssued[issueSlot] <= 1'b1;
      if (memRspValid) begin
        pending[fillIdx]     <= 1'b0;
        mshrBusy[memRspSlot] <= 1'b0;
      end
      if (isMiss) begin
        tagArr[reqIdx]       <= reqTag;
        tagValid[reqIdx]     <= 1'b1;
        pending[reqIdx]      <= 1'b1;
        mshrBusy[freeSlot]   <= 1'b1;
        mshrIssued[freeSlot] <= 1'b0;
        mshrIdx[freeSlot]    <= reqIdx;
        mshrLine[freeSlot]   <= reqLine;
      end
    end
  end

  // Reference counts of queued entries per line index.
  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_ref
      logic incr, decr;
      assign incr = accept  && (reqIdx == IDX_W'(g));
      assign decr = popFire && (popIdx == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (rst)               refCnt[g] <= '0;
        else if (incr && !decr) refCnt[g] <= refCnt[g] + 1'b1;
        else if (decr && !incr) refCnt[g] <= refCnt[g] - 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/tc_data.sv
module tc_data
  import tc_pkg::*;
#(
  parameter int TEXEL_W   = 16,
  parameter int ID_W      = 4,
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 16,
  parameter int MIN_DELAY = 12,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int AGE_W  = $clog2(MIN_DELAY + 1),
  localparam int LINE_BITS = TEXELS_PER_LINE * TEXEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tcStrobe_t            strobe,
  input  logic [IDX_W-1:0]     pushIdx,
  input  logic [OFF_W-1:0]     pushOff,
  input  logic [ID_W-1:0]      pushId,
  input  logic [IDX_W-1:0]     fillIdx,
  input  logic [LINE_BITS-1:0] fillData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [TEXEL_W-1:0]   outData,
  output logic [ID_W-1:0]      outId,
  output logic                 fifoFull,
  output logic                 popFire,
  output logic [IDX_W-1:0]     popIdx
);

  logic [TEXEL_W-1:0] store [NUM_LINES][TEXELS_PER_LINE];

  logic [IDX_W-1:0] eIdx  [DEPTH];
  logic [OFF_W-1:0] eOff  [DEPTH];
  logic [ID_W-1:0]  eId   [DEPTH];
  logic [AGE_W-1:0] eAge  [DEPTH];
  logic [DEPTH-1:0] ePend;

  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;

  assign fifoFull = (count == CNT_W'(DEPTH));
  assign outValid = (count != '0) && (eAge[head] == AGE_W'(MIN_DELAY)) && !ePend[head];
  assign outData  = store[eIdx[head]][eOff[head]];
  assign outId    = eId[head];
  assign popFire  = outValid && outReady;
  assign popIdx   = eIdx[head];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      ePend <= '0;
      for (int e = 0; e < DEPTH; e++) eAge[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (eAge[e] != AGE_W'(MIN_DELAY)) eAge[e] <= eAge[e] + 1'b1;
        if (strobe.fill && (eIdx[e] == fillIdx)) ePend[e] <= 1'b0;
      end
      if (strobe.push) begin
        eIdx[tail]  <= pushIdx;
        eOff[tail]  <= pushOff;
        eId[tail]   <= pushId;
        eAge[tail]  <= '0;
        ePend[tail] <= strobe.pushPend;
        tail        <= nextPtr(tail);
      end
      if (popFire) head <= nextPtr(head);
      if (strobe.push && !popFire)      count <= count + 1'b1;
      else if (popFire && !strobe.push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      for (int k = 0; k < TEXELS_PER_LINE; k++)
        store[fillIdx][k] <= fillData[k*TEXEL_W +: TEXEL_W];
    end
  end

endmodule

// File: rtl/tex_prefetch_cache.sv
module tex_prefetch_cache
  import tc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int TEXEL_W   = 16,
  parameter int ID_W      = 4,
  parameter int NUM_LINES = 8,
  parameter int NUM_MSHR  = 4,
  parameter int DEPTH     = 16,
  parameter int MIN_DELAY = 12,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int SLOT_W = $clog2(NUM_MSHR)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reqValid,
  output logic                           reqReady,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [ID_W-1:0]                reqId,
  output logic                           outValid,
  input  logic                           outReady,
  output logic [TEXEL_W-1:0]             outData,
  output logic [ID_W-1:0]                outId,
  output logic                           memReqValid,
  input  logic                           memReqReady,
  output logic [LINE_W-1:0]              memReqLine,
  output logic [SLOT_W-1:0]              memReqSlot,
  input  logic                           memRspValid,
  input  logic [SLOT_W-1:0]              memRspSlot,
  input  logic [TEXELS_PER_LINE*TEXEL_W-1:0] memRspData
);

  tcStrobe_t        strobe;
  logic [IDX_W-1:0] fillIdx, popIdx;
  logic             fifoFull, popFire;

  tc_ctrl #(
    .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .NUM_MSHR(NUM_MSHR), .DEPTH(DEPTH)
  ) ctrl (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .fifoFull(fifoFull), .popFire(popFire), .popIdx(popIdx),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqLine(memReqLine), .memReqSlot(memReqSlot),
    .memRspValid(memRspValid), .memRspSlot(memRspSlot),
    .strobe(strobe), .fillIdx(fillIdx)
  );

  tc_data #(
    .TEXEL_W(TEXEL_W), .ID_W(ID_W), .NUM_LINES(NUM_LINES),
    .DEPTH(DEPTH), .MIN_DELAY(MIN_DELAY)
  ) data (
    .clk(clk), .rst(rst), .strobe(strobe),
    .pushIdx(reqAddr[OFF_W +: IDX_W]), .pushOff(reqAddr[OFF_W-1:0]), .pushId(reqId),
    .fillIdx(fillIdx), .fillData(memRspData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outId(outId),
    .fifoFull(fifoFull), .popFire(popFire), .popIdx(popIdx)
  );

endmodule

// File: rtl/tex_prefetch_cache_chk.sv
module tex_prefetch_cache_chk #(
  parameter int ADDR_W   = 12,
  parameter int TEXEL_W  = 16,
  parameter int ID_W     = 4,
  parameter int NUM_MSHR = 4,
  localparam int LINE_W = ADDR_W - 2,
  localparam int SLOT_W = $clog2(NUM_MSHR)
) (
  input logic               clk,
  input logic               rst,
  input logic               outValid,
  input logic               outReady,
  input logic [TEXEL_W-1:0] outData,
  input logic [ID_W-1:0]    outId,
  input logic               memReqValid,
  input logic               memReqReady,
  input logic [LINE_W-1:0]  memReqLine,
  input logic [SLOT_W-1:0]  memReqSlot,
  input logic               memRspValid
);

  logic [SLOT_W+1:0] inflight;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else if ((memReqValid && memReqReady) && !memRspValid) inflight <= inflight + 1'b1;
    else if (memRspValid && !(memReqValid && memReqReady)) inflight <= inflight - 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!outValid && !memReqValid));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outId)));

  // R4
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqLine) && $stable(memReqSlot)));

  // R6
  mshr_limit_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= (SLOT_W+2)'(NUM_MSHR));

endmodule

bind tex_prefetch_cache tex_prefetch_cache_chk #(
  .ADDR_W(ADDR_W), .TEXEL_W(TEXEL_W), .ID_W(ID_W), .NUM_MSHR(NUM_MSHR)
) chk (
  .clk(clk), .rst(rst), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outId(outId), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqLine(memReqLine), .memReqSlot(memReqSlot),
  .memRspValid(memRspValid)
);

// File: tb/tex_prefetch_cache_test.sv
`timescale 1ns/1ps
module tex_prefetch_cache_test;

  localparam int ADDR_W = 12, TEXEL_W = 16, ID_W = 4, NSLOT = 4, MIN_DELAY = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic reqValid = 1'b0, reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [ID_W-1:0] reqId = '0;
  logic outValid, outReady = 1'b1;
  logic [TEXEL_W-1:0] outData;
  logic [ID_W-1:0] outId;
  logic memReqValid, memReqReady = 1'b1;
  logic [ADDR_W-3:0] memReqLine;
  logic [1:0] memReqSlot;
  logic memRspValid = 1'b0;
  logic [1:0] memRspSlot = '0;
  logic [4*TEXEL_W-1:0] memRspData = '0;

  tex_prefetch_cache uut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int memReqCount = 0, sentCount = 0, poppedCount = 0, lastLat = 0;
  int outMode = 0, memMode = 0;
  bit memHold = 1'b0;
  logic [TEXEL_W-1:0] expData [$];
  logic [ID_W-1:0] expId [$];
  int acceptCyc [16];
  logic [ID_W-1:0] nextId = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TEXEL_W-1:0] texelOf(input logic [ADDR_W-1:0] a);
    return TEXEL_W'(a) ^ 16'h5A5A;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
    return {7'(tag), 3'(idx), 2'(off)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Memory stub: records accepted reads, answers after a variable delay.
  bit slotActive [NSLOT];
  logic [ADDR_W-3:0] slotLine [NSLOT];
  int slotLeft [NSLOT];
  always @(negedge clk) begin
    if (memRspValid) slotActive[memRspSlot] = 1'b0;
    memRspValid = 1'b0;
    for (int s = 0; s < NSLOT; s++) if (slotActive[s] && slotLeft[s] > 0) slotLeft[s]--;
    if (!memHold) begin
      for (int s = NSLOT - 1; s >= 0; s--) begin
        if (slotActive[s] && slotLeft[s] == 0) begin
          memRspValid = 1'b1;
          memRspSlot = 2'(s);
        end
      end
      if (memRspValid)
        for (int k = 0; k < 4; k++)
          memRspData[k*TEXEL_W +: TEXEL_W] = texelOf({slotLine[memRspSlot], 2'(k)});
    end
    memReqReady = (memMode == 0) ? 1'b1 : ((cyc % 4) != 1);
    outReady = (outMode == 0) ? 1'b1 : (outMode == 1) ? 1'b0 : ((cyc % 3) != 0);
    #1;
    if (memReqValid && memReqReady) begin
      slotActive[memReqSlot] = 1'b1;
      slotLine[memReqSlot] = memReqLine;
      slotLeft[memReqSlot] = 3 + (memReqCount * 5) % 6;
      memReqCount++;
    end
  end

  // Monitor: scoreboard compare, latency and hold checks.
  bit prevStall = 1'b0;
  logic [TEXEL_W-1:0] prevData;
  logic [ID_W-1:0] prevId;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (prevStall)  // R9
        check(outValid && outData == prevData && outId == prevId, "R9 hold",
              {outValid, outData}, {1'b1, prevData});
      if (outValid && outReady) begin
        if (expData.size() == 0) check(1'b0, "R2 unexpected output", outId, 0);
        else begin
          logic [TEXEL_W-1:0] d;
          logic [ID_W-1:0] i;
          d = expData.pop_front();
          i = expId.pop_front();
          check(outData == d, "R2 data", outData, d);
          check(outId == i, "R11 order", outId, i);
          lastLat = cyc - acceptCyc[outId];
          check(lastLat >= MIN_DELAY, "R3 min delay", lastLat, MIN_DELAY);
          poppedCount++;
        end
      end
      prevStall = outValid && !outReady;
      prevData = outData;
      prevId = outId;
    end
  end

  task automatic sendReq(input logic [ADDR_W-1:0] a, output int waits);
    waits = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqId = nextId;
    forever begin
      #1;
      if (reqReady) break;
      waits++;
      @(negedge clk);
    end
    expData.push_back(texelOf(a));
    expId.push_back(nextId);
    @(posedge clk);
    #1;
    acceptCyc[nextId] = cyc;
    nextId++;
    sentCount++;
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (expData.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int w, sumW, base;
    int seed;
    bit stuck, outLow;
    for (int s = 0; s < NSLOT; s++) slotActive[s] = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state visible at the ports
    check(!outValid, "R1 outValid", outValid, 0);
    check(!memReqValid, "R1 memReqValid", memReqValid, 0);
    rst = 1'b0;
    #3;
    check(reqReady, "R1 reqReady", reqReady, 1);

    // R4/R10: back-to-back misses to four lines are not stalled
    sumW = 0; base = memReqCount;
    for (int i = 0; i < 4; i++) begin
      sendReq(mk(1, i, i), w); sumW += w;
    end
    check(sumW == 0, "R4 no stall on miss", sumW, 0);
    repeat (3) @(negedge clk);
    check(memReqCount - base == 4, "R4 one request per miss", memReqCount - base, 4);
    drain();

    // R5: requests merging into an outstanding fill
    base = memReqCount; sumW = 0;
    sendReq(mk(2, 4, 0), w); sumW += w;
    sendReq(mk(2, 4, 3), w); sumW += w;
    sendReq(mk(2, 4, 1), w); sumW += w;
    drain();
    check(memReqCount - base == 1, "R5 merged misses", memReqCount - base, 1);
    check(sumW == 0, "R5 no stall on merge", sumW, 0);

    // R3: a hit into an empty queue takes exactly MIN_DELAY cycles
    base = memReqCount;
    sendReq(mk(1, 0, 2), w);
    drain();
    check(memReqCount == base, "R3 hit issues no read", memReqCount - base, 0);
    check(lastLat == MIN_DELAY, "R3 exact hit delay", lastLat, MIN_DELAY);

    // R6/R7: all slots busy while memory withholds responses
    memHold = 1'b1; base = memReqCount;
    sendReq(mk(3, 5, 0), w);
    sendReq(mk(3, 6, 1), w);
    sendReq(mk(3, 7, 2), w);
    sendReq(mk(3, 0, 3), w);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = mk(3, 1, 0); reqId = nextId;
    stuck = 1'b1; outLow = 1'b1;
    repeat (24) begin
      #1;
      if (reqReady) stuck = 1'b0;
      #2;
      if (outValid) outLow = 1'b0;
      @(negedge clk);
    end
    check(stuck, "R6 fifth miss held off", !stuck, 0);
    check(outLow, "R7 pending head holds output", !outLow, 0);
    check(memReqCount - base == 4, "R6 four reads outstanding", memReqCount - base, 4);
    reqValid = 1'b0;
    memHold = 1'b0;
    sendReq(mk(3, 1, 0), w);
    drain();
    check(memReqCount - base == 5, "R6 fifth read after release", memReqCount - base, 5);

    // R8/R9: locked line blocks a conflicting tag
    outMode = 1;
    sendReq(mk(3, 5, 1), w);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = mk(4, 5, 0); reqId = nextId;
    stuck = 1'b1;
    repeat (20) begin
      #1;
      if (reqReady) stuck = 1'b0;
      @(negedge clk);
    end
    check(stuck, "R8 conflict held off", !stuck, 0);
    #3;
    check(outValid, "R9 output waiting under backpressure", outValid, 1);
    reqValid = 1'b0;
    outMode = 0;
    sendReq(mk(4, 5, 0), w);
    drain();

    // R10/R11: mixed stream with output and memory backpressure
    outMode = 2; memMode = 1; seed = 7;
    for (int n = 0; n < 60; n++) begin
      seed = seed * 1103515245 + 12345;
      sendReq(mk((seed >>> 20) & 3, (seed >>> 16) & 7, (seed >>> 8) & 3), w);
    end
    drain();
    check(poppedCount == sentCount, "R11 every request answered", poppedCount, sentCount);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule